// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a bus-mapped watchdog for a processor subsystem. A free-running tick input is first divided by 32, and the divided ticks are counted against a terminal value of two to the power of a postscaler setting. If software lets the count reach that terminal value, the block raises a one-cycle reset request. It also sets a sticky timeout flag, which survives until software clears it on purpose. Software keeps the system alive by writing a fixed 16-bit key into the upper half of the control word. That write restarts the count. Any other value written there does nothing.

The postscaler, the clock-select code and the windowed-mode indication are captured from configuration inputs while reset is held. After that they are visible to software but cannot be written. The only writable control bit is the enable bit. It can be written directly, or changed through write-1-to-clear and write-1-to-set alias addresses. The cycle that follows a clear of the enable bit is a dead cycle in which every bus write is dropped. The block does not generate the tick and does not carry out the system reset.

Top module: `kwdt_top`

## Requirements
- R1: After reset the enable bit and the timeout flag are 0 and `rst_req` is low. The control word at offset 0x00 reads the captured postscaler in bits 12:8, the clock-select code in bits 7:6 and the windowed-mode indication in bit 0.
- R2: The postscaler, clock-select and windowed-mode fields are read-only. No write to offset 0x00, 0x04 or 0x08 changes them. Bit 15 (enable) is the only control bit that can be written, and only when byte enable 1 is set.
- R3: A write to offset 0x04 with bit 15 set clears the enable bit. A write to offset 0x08 with bit 15 set sets it. A plain write to 0x00 loads bit 15 as written.
- R4: While enabled, the block divides `tick_en` pulses by 32. The `rst_req` output goes high for exactly one cycle, in the clock cycle after the edge that takes the (32 × 2^postscaler)-th tick since the last restart.
- R5: After an expiry the count restarts from zero, so the next expiry follows another 32 × 2^postscaler ticks.
- R6: A write to offset 0x00 with byte enables 3 and 2 both set and data bits 31:16 equal to 0x5743 restarts the count. Any other value in those bits, or a write with only one of those byte enables set, leaves the count unchanged.
- R7: While disabled, ticks are ignored and no reset request is produced. Setting the enable bit starts the count from zero.
- R8: The timeout flag is bit 4 of the status word at offset 0x10. It is set on every expiry and stays set through writes to 0x10. It is cleared only by writing 1 to bit 4 at offset 0x14.
- R9: In the cycle that immediately follows a clear of the enable bit, every bus write is ignored, including alias writes and status clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| tick_en | input | 1 | One pulse per source tick, counted before the divide-by-32 |
| cfg_postscale | input | 5 | Postscaler exponent, captured during reset |
| cfg_clksel | input | 2 | Clock-select code, captured during reset, readback only |
| cfg_window | input | 1 | Windowed-mode indication, captured during reset, readback only |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | 4 | Byte enables for the write data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while a read is selected |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong count state shows up only as a reset request in the wrong cycle. That can happen up to one full period later (32 × 2^postscaler ticks), so the bench predicts the exact cycle of every request and reports both early and missing ones. A stuck or wrongly held enable bit, a wrongly held flag or a lost configuration field is visible at once through a read of the control or status word. The dead cycle after disabling is observed through the enable bit and the flag right after the dropped write.

// File: rtl/kwdt_pkg.sv
// Package: register offsets, bit positions, key value and configuration type
// shared by the watchdog modules. Assumes a 32-bit data bus with byte enables.
package kwdt_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int PS_W     = 5;
    localparam int CS_W     = 2;
    localparam int PRE_LOG2 = 5;

    localparam logic [ADDR_W-1:0] A_CTRL     = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTRL_CLR = 5'h04;
    localparam logic [ADDR_W-1:0] A_CTRL_SET = 5'h08;
    localparam logic [ADDR_W-1:0] A_STAT     = 5'h10;
    localparam logic [ADDR_W-1:0] A_STAT_CLR = 5'h14;

    localparam logic [15:0] KICK_KEY = 16'h5743;

    localparam int B_ON     = 15;
    localparam int B_WIN    = 0;
    localparam int PS_LSB   = 8;
    localparam int CS_LSB   = 6;
    localparam int B_TOFLAG = 4;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic [CS_W-1:0] cs;
        logic            win;
    } cfg_t;

endpackage

// File: rtl/kwdt_prediv.sv
// Module: fixed power-of-two pre-divider for the source tick.
// Emits one pulse for every 2**LOG2 accepted tick pulses while run is high.
// Assumes clear has priority over counting; counter held at zero when not run.
module kwdt_prediv #(
    parameter int LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick_en,
    output logic pre_tick
);

    generate
        if (LOG2 == 0) begin : g_bypass
            // Purpose: no division, pass accepted ticks straight through.
            assign pre_tick = run & tick_en & ~clear;
        end else begin : g_div
            logic [LOG2-1:0] cnt_q;

            // Purpose: count accepted ticks, restart on clear or when stopped.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run || clear) begin
                    cnt_q <= '0;
                end else if (tick_en) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            // Purpose: pulse on the tick that completes a full divide period.
            assign pre_tick = run & tick_en & ~clear & (&cnt_q);

            // R7: a stopped divider sits at zero one cycle later
            a_r7_prediv_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/kwdt_postcnt.sv
// Module: postscaled terminal counter. Counts divided ticks and flags expiry
// when 2**ps of them have been seen since the last restart, then rewinds.
// Assumes ps is stable while running (it is captured at reset).
module kwdt_postcnt #(
    parameter int PS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic            step,
    input  logic [PS_W-1:0] ps,
    output logic            expire
);

    localparam int CNT_W = 2 ** PS_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_m1;

    // Purpose: last count value before expiry, a mask of ps low ones.
    always_comb begin
        term_m1 = (CNT_W'(1) << ps) - CNT_W'(1);
    end

    // Purpose: expiry when the step lands on the terminal value.
    assign expire = run & step & ~clear & (cnt_q == term_m1);

    // Purpose: advance on each divided tick, rewind on expiry, clear or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

    // R5: count never passes the terminal value
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term_m1);

    // R5: after an expiry the count starts over
    a_r5_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/kwdt_regs.sv
// Module: bus register file. Holds the enable bit, the sticky timeout flag,
// the configuration captured at reset and the post-disable dead cycle.
// Decodes key writes into a restart pulse. Assumes single-cycle writes.
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    output logic              en,
    output logic              kick,
    output cfg_t              cfg
);

    logic  en_q, en_next;
    logic  guard_q;
    logic  flag_q;
    logic  flag_clr;
    logic  wr_ok;
    cfg_t  cfg_q;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;
    logic  unused_bits;

    // Purpose: a write is honoured unless it falls in the dead cycle.
    assign wr_ok = bus_sel & bus_wr & ~guard_q;

    // Purpose: next value of the enable bit from direct and alias writes.
    always_comb begin
        en_next = en_q;
        if (wr_ok && bus_be[B_ON/8]) begin
            case (bus_addr)
                A_CTRL:     en_next = bus_wdata[B_ON];
                A_CTRL_CLR: if (bus_wdata[B_ON]) en_next = 1'b0;
                A_CTRL_SET: if (bus_wdata[B_ON]) en_next = 1'b1;
                default:    en_next = en_q;
            endcase
        end
    end

    // Purpose: restart pulse on a full upper half-word carrying the key.
    assign kick = wr_ok && (bus_addr == A_CTRL) && (&bus_be[3:2])
                  && (bus_wdata[31:16] == KICK_KEY);

    // Purpose: write-1-to-clear request for the timeout flag.
    assign flag_clr = wr_ok && (bus_addr == A_STAT_CLR)
                      && bus_be[B_TOFLAG/8] && bus_wdata[B_TOFLAG];

    // Purpose: state update; configuration loads while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            guard_q <= 1'b0;
            flag_q  <= 1'b0;
            cfg_q   <= cfg_in;
        end else begin
            en_q    <= en_next;
            guard_q <= en_q & ~en_next;
            flag_q  <= expire | (flag_q & ~flag_clr);
        end
    end

    // Purpose: assemble the readable words from state and configuration.
    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[B_ON]              = en_q;
        ctrl_word[PS_LSB +: PS_W]    = cfg_q.ps;
        ctrl_word[CS_LSB +: CS_W]    = cfg_q.cs;
        ctrl_word[B_WIN]             = cfg_q.win;
        stat_word                    = '0;
        stat_word[B_TOFLAG]          = flag_q;
    end

    // Purpose: read mux; alias offsets read back the control word.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_CTRL, A_CTRL_CLR, A_CTRL_SET: bus_rdata = ctrl_word;
                A_STAT, A_STAT_CLR:             bus_rdata = stat_word;
                default:                        bus_rdata = '0;
            endcase
        end
    end

    assign unused_bits = ^bus_wdata ^ ^bus_be;
    assign en  = en_q;
    assign cfg = cfg_q;

    // R8: every expiry leaves the flag set
    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);

    // R8: the flag only drops through the clear alias
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R9: the enable bit cannot move during the dead cycle
    a_r9_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        guard_q |=> $stable(en_q));

    // R2: bus writes never alter the captured configuration
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> $stable(cfg_q));

endmodule

// File: rtl/kwdt_top.sv
// Module: keyed-clear watchdog top. Joins the register file, the fixed
// pre-divider and the postscaled counter, and registers the reset request.
// Assumes tick_en is synchronous to clk and at most one pulse per cycle.
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [PS_W-1:0]   cfg_postscale,
    input  logic [CS_W-1:0]   cfg_clksel,
    input  logic              cfg_window,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    cfg_t cfg_in;
    cfg_t cfg;
    logic en;
    logic kick;
    logic pre_tick;
    logic expire;
    logic rst_req_q;

    assign cfg_in = '{ps: cfg_postscale, cs: cfg_clksel, win: cfg_window};

    kwdt_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_in    (cfg_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (expire),
        .en        (en),
        .kick      (kick),
        .cfg       (cfg)
    );

    kwdt_prediv #(.LOG2(PRE_LOG2)) i_prediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en),
        .clear    (kick),
        .tick_en  (tick_en),
        .pre_tick (pre_tick)
    );

    kwdt_postcnt #(.PS_W(PS_W)) i_postcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .clear  (kick),
        .step   (pre_tick),
        .ps     (cfg.ps),
        .expire (expire)
    );

    // Purpose: register the expiry into a one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= expire;
        end
    end

    assign rst_req = rst_req_q;

    // R4: the reset request never lasts two cycles
    a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: no request follows a disabled cycle
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rst_req);

    // R6: a key write yields no request on the next cycle
    a_r6_kick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_req);

endmodule

// File: tb/test_kwdt_top.sv
// Bench: scoreboard of predicted reset-request cycles plus register readbacks.
module test_kwdt_top;

    localparam int PS   = 2;
    localparam int TERM = 32 << PS;
    localparam logic [31:0] CTRL_OFF = 32'h0000_0281;
    localparam logic [31:0] CTRL_ON  = 32'h0000_8281;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic [4:0]  cfg_postscale;
    logic [1:0]  cfg_clksel;
    logic        cfg_window;
    logic        bus_sel;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        rst_req;

    always #4 clk = ~clk;

    kwdt_top i_kwdt_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .cfg_postscale (cfg_postscale),
        .cfg_clksel    (cfg_clksel),
        .cfg_window    (cfg_window),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .rst_req       (rst_req)
    );

    typedef struct {
        int unsigned at;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int unsigned cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          started = 1'b0;
    bit          model_en = 1'b0;
    int          model_cnt = 0;
    string       phase = "R1";
    logic [31:0] rd;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                             input logic [3:0] be);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: applies ticks and pushes predicted request cycles.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            if (model_en) begin
                model_cnt++;
                if (model_cnt == TERM) begin
                    sb_q.push_back('{at: cyc + 1, tag: phase});
                    model_cnt = 0;
                end
            end
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    // Monitor: pops predictions as requests appear, reports extra or missing.
    always @(negedge clk) begin
        if (started) begin
            if (rst_req) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, phase, "unexpected reset request", cyc, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.at == cyc, e.tag, "reset request cycle", cyc, e.at);
                end
            end else if (sb_q.size() > 0 && sb_q[0].at < cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                check(1'b0, e.tag, "missing reset request", cyc, e.at);
            end
        end
    end

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", "run did not finish", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_be = '0; bus_wdata = '0;
        cfg_postscale = 5'(PS); cfg_clksel = 2'b10; cfg_window = 1'b1;
        idle(4);
        rst_n = 1'b1;
        cfg_postscale = 5'd7; cfg_clksel = 2'b01; cfg_window = 1'b0;
        started = 1'b1;
        idle(1);

        // R1: reset state
        check(rst_req == 1'b0, "R1", "rst_req after reset", 32'(rst_req), 0);
        bus_read(5'h00, rd); check(rd == CTRL_OFF, "R1", "control word", rd, CTRL_OFF);
        bus_read(5'h10, rd); check(rd == 0, "R1", "status word", rd, 0);

        // R2: read-only fields survive direct and set-alias writes
        phase = "R2";
        bus_write(5'h00, 32'h0000_7FFF, 4'b0011);
        bus_read(5'h00, rd); check(rd == CTRL_OFF, "R2", "direct write", rd, CTRL_OFF);
        bus_write(5'h08, 32'h0000_1FC1, 4'b0011);
        bus_read(5'h00, rd); check(rd == CTRL_OFF, "R2", "set alias on fields", rd, CTRL_OFF);

        // R3: direct enable, clear alias, set alias
        phase = "R3";
        bus_write(5'h00, 32'h0000_8000, 4'b0011); model_en = 1; model_cnt = 0;
        bus_read(5'h00, rd); check(rd == CTRL_ON, "R3", "direct enable", rd, CTRL_ON);
        bus_write(5'h04, 32'h0000_8000, 4'b0011); model_en = 0; model_cnt = 0;
        idle(1);
        bus_read(5'h00, rd); check(rd == CTRL_OFF, "R3", "clear alias", rd, CTRL_OFF);
        bus_write(5'h08, 32'h0000_8000, 4'b0011); model_en = 1; model_cnt = 0;
        bus_read(5'h00, rd); check(rd == CTRL_ON, "R3", "set alias", rd, CTRL_ON);

        // R4, R5: first expiry and the one after it
        phase = "R4"; tick(TERM);
        phase = "R5"; tick(TERM + 10);
        idle(2);

        // R8: sticky flag and its clear alias
        phase = "R8";
        bus_read(5'h10, rd); check(rd == 32'h10, "R8", "flag after expiry", rd, 32'h10);
        bus_write(5'h10, 32'h0000_0010, 4'b0001);
        bus_read(5'h10, rd); check(rd == 32'h10, "R8", "flag after plain write", rd, 32'h10);
        bus_write(5'h14, 32'h0000_0010, 4'b0001);
        bus_read(5'h10, rd); check(rd == 0, "R8", "flag after clear alias", rd, 0);

        // R6: key restarts, wrong key and partial half-word do not
        phase = "R6";
        tick(50);
        bus_write(5'h00, 32'h5743_0000, 4'b1100); model_cnt = 0;
        tick(TERM);
        tick(40);
        bus_write(5'h00, 32'h1234_0000, 4'b1100);
        bus_write(5'h00, 32'h0043_0000, 4'b0100);
        bus_write(5'h00, 32'h5743_0000, 4'b0100);
        tick(TERM - 40);
        tick(60);
        bus_write(5'h00, 32'h5743_8000, 4'b1111); model_cnt = 0;
        tick(TERM);
        bus_read(5'h00, rd); check(rd == CTRL_ON, "R6", "full-word key keeps enable", rd, CTRL_ON);

        // R7: disabled count is frozen, re-enable starts from zero
        phase = "R7";
        tick(30);
        bus_write(5'h04, 32'h0000_8000, 4'b0011); model_en = 0; model_cnt = 0;
        idle(1);
        tick(3 * TERM);
        bus_read(5'h00, rd); check(rd == CTRL_OFF, "R7", "still disabled", rd, CTRL_OFF);
        bus_write(5'h08, 32'h0000_8000, 4'b0011); model_en = 1; model_cnt = 0;
        tick(TERM);

        // R9: writes in the dead cycle are dropped
        phase = "R9";
        bus_write(5'h04, 32'h0000_8000, 4'b0011); model_en = 0; model_cnt = 0;
        bus_write(5'h14, 32'h0000_0010, 4'b0001);
        bus_read(5'h10, rd); check(rd == 32'h10, "R9", "flag clear in dead cycle", rd, 32'h10);
        bus_write(5'h08, 32'h0000_8000, 4'b0011); model_en = 1; model_cnt = 0;
        bus_write(5'h04, 32'h0000_8000, 4'b0011); model_en = 0; model_cnt = 0;
        bus_write(5'h08, 32'h0000_8000, 4'b0011);
        bus_read(5'h00, rd); check(rd == CTRL_OFF, "R9", "set alias in dead cycle", rd, CTRL_OFF);
        tick(TERM);

        idle(5);
        check(sb_q.size() == 0, "R4", "predicted requests left over", 32'(sb_q.size()), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule